// File: doc/BRIEF.md
# Block-Lock Write Protection Unit

This unit decides, for every requested nonvolatile program operation on a 2K x 8 byte array, whether it may go ahead. It holds a small protection register made of three parts. The first is a volatile write-enable latch that must be set before anything nonvolatile is written. The second is a two-bit lock field that protects none, the top quarter, the top half or all of the array. The third is a hardware-protect enable bit that, while the protect pin is held low, freezes the lock field and the enable bit itself.

The surrounding controller decodes the highest location of the address space as the protection register and presents writes there on the register-write path. Ordinary array writes arrive as a program request with a byte address. Every request produces a one-cycle grant or deny pulse on the cycle after it is presented. The register contents can always be read back.

Top module: `blg_guard`

## Requirements
- R1: While reset is asserted and on the first cycle after it, grant and deny are 0 and the write-enable latch (readback bit 1) is 0.
- R2: A program request made while the write-enable latch is 0 is denied, whatever the address.
- R3: A register write of exactly 0x02 sets the write-enable latch and a write of exactly 0x00 clears it. No other value changes the latch. Both of these latch commands are always granted.
- R4: The lock field selects the protected address range: 00 protects nothing, 01 protects 0x600-0x7FF, 10 protects 0x400-0x7FF and 11 protects 0x000-0x7FF. A program request inside the protected range is denied.
- R5: A program request outside the protected range while the latch is 1 is granted. Grant and deny are pulses exactly one cycle long, appear on the cycle after the request, and are never high together.
- R6: A register write of any value other than 0x00 or 0x02 is a field update. It loads the lock field from data bits [3:2] and the hardware-protect enable from data bit 7, and leaves the latch unchanged. It is granted only while the latch is 1; otherwise it is denied and the register is unchanged.
- R7: Hardware protection is active when the enable bit is 1 and the protect pin is low. While it is active, every field update is denied and the lock field and enable bit hold. With the pin high, field updates proceed as in R6.
- R8: The lock field protects its range whether or not hardware protection is enabled or the pin is high.
- R9: A register write and a program request presented in the same cycle are both rejected: one deny pulse results and the register is unchanged.
- R10: Reset clears only the latch. The lock field and the hardware-protect enable keep their values through reset.
- R11: Readback layout: bit 1 = latch, bits [3:2] = lock field, bit 7 = hardware-protect enable, all other bits 0. It reflects an accepted write on the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_req | input | 1 | Program-request strobe for the array |
| prog_addr | input | 11 | Target byte address of the program request |
| reg_wr | input | 1 | Write strobe for the protection register |
| reg_data | input | 8 | Data for the protection register write |
| prot_pin | input | 1 | Hardware-protect pin; low arms hardware protection |
| grant | output | 1 | One-cycle pulse: the request was accepted |
| deny | output | 1 | One-cycle pulse: the request was rejected |
| prot_rb | output | 8 | Current protection register value |

## Verification
A wrong latch state shows on the very next program request as a grant where a deny belongs, or the reverse, and it also shows at once in readback bit 1. A lock-field or decode error shows only for addresses near the quarter boundaries, so requests are placed on both sides of 0x400 and 0x600. A freeze fault shows as a readback change after a field update made with the pin low, one cycle after that write. Reset is exercised with protection fields set, so that a field wrongly cleared by reset appears in readback on the cycle after reset is released.

// File: rtl/blg_pkg.sv
package blg_pkg;
  localparam int REG_W    = 8;
  localparam int WEL_BIT  = 1;
  localparam int LOCK_LO  = 2;
  localparam int HWEN_BIT = 7;
  localparam logic [REG_W-1:0] CMD_WEL_SET = 8'h02;
  localparam logic [REG_W-1:0] CMD_WEL_CLR = 8'h00;

  typedef enum logic [1:0] {
    LOCK_NONE = 2'b00,
    LOCK_QTR  = 2'b01,
    LOCK_HALF = 2'b10,
    LOCK_ALL  = 2'b11
  } lock_sel_e;

  function automatic logic [2:0] quarters_locked(lock_sel_e s);
    case (s)
      LOCK_NONE: return 3'd0;
      LOCK_QTR:  return 3'd1;
      LOCK_HALF: return 3'd2;
      default:   return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/blg_region_decode.sv
module blg_region_decode
  import blg_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic [ADDR_W-1:0] addr,
  input  lock_sel_e         sel,
  output logic              hit
);
  localparam int NQ = 4;

  logic [2:0]    nlock;
  logic [2:0]    first_locked;
  logic [NQ-1:0] mask;
  logic [1:0]    quarter;

  assign nlock        = quarters_locked(sel);
  assign first_locked = 3'(NQ) - nlock;
  assign quarter      = addr[ADDR_W-1 -: 2];

  for (genvar gi = 0; gi < NQ; gi++) begin : g_qmask
    assign mask[gi] = (3'(gi) >= first_locked);
  end

  assign hit = mask[quarter];
endmodule

// File: rtl/blg_prot_reg.sv
module blg_prot_reg
  import blg_pkg::*;
#(
  parameter lock_sel_e   INIT_LOCK = LOCK_NONE,
  parameter logic        INIT_HWEN = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             pin,
  output logic             wel,
  output lock_sel_e        lock,
  output logic             hw_en,
  output logic             accept
);
  logic      wel_q;
  lock_sel_e lock_q = INIT_LOCK;
  logic      hw_q   = INIT_HWEN;

  logic is_set, is_clr, latch_cmd, frozen, field_ok;

  assign is_set    = (wr_data == CMD_WEL_SET);
  assign is_clr    = (wr_data == CMD_WEL_CLR);
  assign latch_cmd = is_set | is_clr;
  assign frozen    = hw_q & ~pin;
  assign field_ok  = wel_q & ~frozen;
  assign accept    = latch_cmd | field_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      wel_q <= 1'b0;
    end else if (wr_en) begin
      if (is_set)      wel_q <= 1'b1;
      else if (is_clr) wel_q <= 1'b0;
    end
  end

  // nonvolatile fields: not touched by reset
  always_ff @(posedge clk) begin
    if (wr_en && !latch_cmd && field_ok) begin
      lock_q <= lock_sel_e'(wr_data[LOCK_LO +: 2]);
      hw_q   <= wr_data[HWEN_BIT];
    end
  end

  assign wel   = wel_q;
  assign lock  = lock_q;
  assign hw_en = hw_q;

  p_wel_reset_r1: assert property (@(posedge clk) rst |=> !wel_q);

  p_frozen_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && frozen && !latch_cmd) |=> ($stable(lock_q) && $stable(hw_q)));

  p_field_needs_wel_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wel_q && !latch_cmd) |=> ($stable(lock_q) && $stable(hw_q)));
endmodule

// File: rtl/blg_response.sv
module blg_response (
  input  logic clk,
  input  logic rst,
  input  logic req_reg,
  input  logic req_prog,
  input  logic reg_ok,
  input  logic prog_ok,
  output logic grant,
  output logic deny
);
  logic collide, any, ok;
  logic grant_q, deny_q;

  assign collide = req_reg & req_prog;
  assign any     = req_reg | req_prog;
  always_comb begin
    if (collide)       ok = 1'b0;
    else if (req_reg)  ok = reg_ok;
    else if (req_prog) ok = prog_ok;
    else               ok = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q <= 1'b0;
      deny_q  <= 1'b0;
    end else begin
      grant_q <= any & ok;
      deny_q  <= any & ~ok;
    end
  end

  assign grant = grant_q;
  assign deny  = deny_q;

  p_exclusive_r5: assert property (@(posedge clk) disable iff (rst)
    !(grant_q && deny_q));

  p_collide_r9: assert property (@(posedge clk) disable iff (rst)
    collide |=> deny_q);
endmodule

// File: rtl/blg_guard.sv
module blg_guard
  import blg_pkg::*;
#(
  parameter int        ADDR_W    = 11,
  parameter lock_sel_e INIT_LOCK = LOCK_NONE,
  parameter logic      INIT_HWEN = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prog_req,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_data,
  input  logic              prot_pin,
  output logic              grant,
  output logic              deny,
  output logic [REG_W-1:0]  prot_rb
);
  logic      wel, hw_en, reg_ok, hit, prog_ok;
  lock_sel_e lock;

  blg_prot_reg #(
    .INIT_LOCK(INIT_LOCK),
    .INIT_HWEN(INIT_HWEN)
  ) u_reg (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (reg_wr & ~prog_req),
    .wr_data(reg_data),
    .pin    (prot_pin),
    .wel    (wel),
    .lock   (lock),
    .hw_en  (hw_en),
    .accept (reg_ok)
  );

  blg_region_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(prog_addr),
    .sel (lock),
    .hit (hit)
  );

  assign prog_ok = wel & ~hit;

  blg_response u_rsp (
    .clk     (clk),
    .rst     (rst),
    .req_reg (reg_wr),
    .req_prog(prog_req),
    .reg_ok  (reg_ok),
    .prog_ok (prog_ok),
    .grant   (grant),
    .deny    (deny)
  );

  always_comb begin
    prot_rb                      = '0;
    prot_rb[WEL_BIT]             = wel;
    prot_rb[LOCK_LO +: 2]        = lock;
    prot_rb[HWEN_BIT]            = hw_en;
  end

  p_wel_gate_r2: assert property (@(posedge clk) disable iff (rst)
    (prog_req && !reg_wr && !wel) |=> deny);

  p_locked_r4: assert property (@(posedge clk) disable iff (rst)
    (prog_req && !reg_wr && hit) |=> !grant);

  p_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    (!prog_req && !reg_wr) |=> (!grant && !deny));
endmodule

// File: tb/blg_guard_test.sv
module blg_guard_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        prog_req = 1'b0;
  logic [10:0] prog_addr = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_data = '0;
  logic        prot_pin = 1'b1;
  logic        grant, deny;
  logic [7:0]  prot_rb;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  blg_guard uut (
    .clk(clk), .rst(rst), .prog_req(prog_req), .prog_addr(prog_addr),
    .reg_wr(reg_wr), .reg_data(reg_data), .prot_pin(prot_pin),
    .grant(grant), .deny(deny), .prot_rb(prot_rb)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one request, result sampled at the following negedge; g/d = expected grant/deny
  task automatic do_prog(string req, logic [10:0] a, logic g);
    @(negedge clk); prog_req = 1'b1; prog_addr = a;
    @(negedge clk); prog_req = 1'b0;
    chk(req, {6'b0, grant, deny}, {6'b0, g, ~g});
  endtask

  task automatic do_reg(string req, logic [7:0] d, logic g, logic [7:0] rb);
    @(negedge clk); reg_wr = 1'b1; reg_data = d;
    @(negedge clk); reg_wr = 1'b0;
    chk(req, {6'b0, grant, deny}, {6'b0, g, ~g});
    chk(req, prot_rb, rb);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", {6'b0, grant, deny}, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", {6'b0, grant, deny}, 8'h00);
  endtask

  task automatic t_no_wel;
    chk("R1", prot_rb, 8'h00);
    do_prog("R2", 11'h000, 1'b0);
    do_prog("R2", 11'h7FF, 1'b0);
    do_reg("R6", 8'h06, 1'b0, 8'h00);
    do_reg("R3", 8'h03, 1'b0, 8'h00);
  endtask

  task automatic t_wel_and_pulse;
    do_reg("R3", 8'h02, 1'b1, 8'h02);
    do_prog("R5", 11'h7FF, 1'b1);
    @(negedge clk);
    chk("R5", {6'b0, grant, deny}, 8'h00);
  endtask

  task automatic t_lock_ranges;
    do_reg("R11", 8'h04, 1'b1, 8'h06);
    do_prog("R4", 11'h5FF, 1'b1);
    do_prog("R4", 11'h600, 1'b0);
    do_reg("R6", 8'h08, 1'b1, 8'h0A);
    do_prog("R4", 11'h3FF, 1'b1);
    do_prog("R4", 11'h400, 1'b0);
    do_reg("R6", 8'h0E, 1'b1, 8'h0E);
    do_prog("R4", 11'h000, 1'b0);
    do_reg("R3", 8'h00, 1'b1, 8'h0C);
    do_reg("R6", 8'h04, 1'b0, 8'h0C);
    do_reg("R3", 8'h02, 1'b1, 8'h0E);
    do_reg("R6", 8'h00 | 8'h01, 1'b1, 8'h02);
    do_prog("R4", 11'h000, 1'b1);
  endtask

  task automatic t_hw_protect;
    prot_pin = 1'b1;
    do_reg("R7", 8'h84, 1'b1, 8'h86);
    do_prog("R8", 11'h600, 1'b0);
    do_prog("R8", 11'h100, 1'b1);
    prot_pin = 1'b0;
    do_reg("R7", 8'h08, 1'b0, 8'h86);
    do_reg("R7", 8'h04, 1'b0, 8'h86);
    do_prog("R8", 11'h7FF, 1'b0);
    do_reg("R7", 8'h00, 1'b1, 8'h84);
    do_reg("R7", 8'h02, 1'b1, 8'h86);
  endtask

  task automatic t_collide;
    @(negedge clk); reg_wr = 1'b1; reg_data = 8'h00; prog_req = 1'b1; prog_addr = 11'h100;
    @(negedge clk); reg_wr = 1'b0; prog_req = 1'b0;
    chk("R9", {6'b0, grant, deny}, 8'h01);
    chk("R9", prot_rb, 8'h86);
  endtask

  task automatic t_reset_keeps;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R10", prot_rb, 8'h84);
    prot_pin = 1'b1;
    do_prog("R10", 11'h100, 1'b0);
  endtask

  initial begin
    t_reset();
    t_no_wel();
    t_wel_and_pulse();
    t_lock_ranges();
    t_hw_protect();
    t_collide();
    t_reset_keeps();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule